// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Counter

This block measures an oscillator against a slow reference clock. It counts cycles of the fast clock it runs on during a fixed window of reference periods. The window opens on a rising edge of the reference and closes on the sixteenth falling edge after that. When the window closes, the result is frozen and a ready flag is raised. Software divides the held count by the window length to get the oscillator frequency.

Four events start a new measurement:
- the RC oscillator is the selected source and its stable flag goes high;
- the crystal oscillator is the selected source and its stable flag goes high;
- the source selection changes;
- software pulses a measure request.

Every start clears the count and the ready flag. Counting then waits for the next reference rising edge. The reference clock is asynchronous to the fast clock, so it passes through a synchronizer before its edges are detected. The four trigger inputs must be synchronous to the fast clock.

Top module: `clk_freq_meter`

## Requirements
- R1: Counting begins at the first synchronized reference rising edge after a trigger. The count then rises by one per fast cycle, so the held result equals the number of fast cycles from that rising edge to the closing falling edge: high time + 15 × period, in fast cycles.
- R2: With `src_sel_i` = 0 (RC selected), a low-to-high change of `rc_stable_i` starts a measurement.
- R3: With `src_sel_i` = 1 (crystal selected), a low-to-high change of `xtal_stable_i` starts a measurement.
- R4: Any change of `src_sel_i`, in either direction, starts a measurement.
- R5: A one-cycle pulse on `meas_req_i` starts a measurement.
- R6: On the 16th synchronized reference falling edge after counting begins, `ready_o` goes to 1. From then on `count_o` holds its value until the next trigger.
- R7: A trigger sampled at a clock edge leaves `count_o` = 0 and `ready_o` = 0 after that edge.
- R8: A trigger that arrives during a measurement restarts it. The later result covers a full window measured from the restart.
- R9: These do not start a measurement and leave a held result unchanged:
  - a stable flag that stays high;
  - a stable flag falling;
  - a rise of the stable flag of the oscillator that is not selected.
- R10: `count_o` saturates at 16'hFFFF instead of wrapping.
- R11: After reset, `count_o` = 0 and `ready_o` = 0, and no measurement runs until a trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock under measurement |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous |
| src_sel_i | input | 1 | Oscillator selection: 0 RC, 1 crystal |
| rc_stable_i | input | 1 | RC oscillator stable flag |
| xtal_stable_i | input | 1 | Crystal oscillator stable flag |
| meas_req_i | input | 1 | Software measure request strobe |
| count_o | output | 16 | Fast cycles counted in the window |
| ready_o | output | 1 | Measurement complete, count held |

## Verification
The reference is generated with several high and low times, some of them unequal. The bench can then tell a window that correctly spans from a rising edge to the 16th falling edge from one that is off by an edge or a half period.

Each of the four trigger kinds is used to start a measurement, which shows that each path reaches the window logic. A restart in mid-window distinguishes a true restart from a measurement that simply continues. Non-triggering flag moves on a held result separate edge detection from level detection. A reference slow enough to overflow 16 bits exposes wrap-around.

// File: rtl/clk_freq_meter_pkg.sv
package clk_freq_meter_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_ARMED = 2'd1,
    WIN_COUNT = 2'd2
  } win_state_e;

  typedef enum logic {
    SRC_RC   = 1'b0,
    SRC_XTAL = 1'b1
  } osc_src_e;
endpackage

// File: rtl/slow_edge_sync.sv
module slow_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= slow_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], slow_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/freq_trigger.sv
module freq_trigger
  import clk_freq_meter_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_sel_i,
  input  logic rc_stable_i,
  input  logic xtal_stable_i,
  input  logic meas_req_i,
  output logic trig_o
);
  logic rc_q, xtal_q, sel_q;
  logic rc_hit, xtal_hit, sel_hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rc_q   <= 1'b0;
      xtal_q <= 1'b0;
      sel_q  <= SRC_RC;
    end else begin
      rc_q   <= rc_stable_i;
      xtal_q <= xtal_stable_i;
      sel_q  <= src_sel_i;
    end

  // edge-qualified so a flag held high fires once
  assign rc_hit   = (src_sel_i == SRC_RC)   & rc_stable_i   & ~rc_q;
  assign xtal_hit = (src_sel_i == SRC_XTAL) & xtal_stable_i & ~xtal_q;
  assign sel_hit  = src_sel_i ^ sel_q;
  assign trig_o   = rc_hit | xtal_hit | sel_hit | meas_req_i;
endmodule

// File: rtl/freq_window.sv
module freq_window
  import clk_freq_meter_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned WIN_FALLS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o,
  output logic             counting_o
);
  localparam int unsigned FW = (WIN_FALLS > 1) ? $clog2(WIN_FALLS) : 1;
  localparam logic [FW-1:0] LAST_FALL = FW'(WIN_FALLS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  win_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FW-1:0]    falls_q;
  logic             ready_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      falls_q <= '0;
      ready_q <= 1'b0;
    end else if (trig_i) begin
      state_q <= WIN_ARMED;
      cnt_q   <= '0;
      falls_q <= '0;
      ready_q <= 1'b0;
    end else begin
      case (state_q)
        WIN_ARMED: if (rise_i) state_q <= WIN_COUNT;
        WIN_COUNT: begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
          if (fall_i) begin
            if (falls_q == LAST_FALL) begin
              state_q <= WIN_IDLE;
              ready_q <= 1'b1;
            end else begin
              falls_q <= falls_q + FW'(1);
            end
          end
        end
        default: state_q <= WIN_IDLE;
      endcase
    end

  assign count_o    = cnt_q;
  assign ready_o    = ready_q;
  assign counting_o = (state_q == WIN_COUNT);
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WIN_FALLS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_clk_i,
  input  logic             src_sel_i,
  input  logic             rc_stable_i,
  input  logic             xtal_stable_i,
  input  logic             meas_req_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o
);
  logic trig, rise_edge, fall_edge, counting;

  slow_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slow_i(slow_clk_i),
    .rise_o(rise_edge),
    .fall_o(fall_edge)
  );

  freq_trigger u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_sel_i    (src_sel_i),
    .rc_stable_i  (rc_stable_i),
    .xtal_stable_i(xtal_stable_i),
    .meas_req_i   (meas_req_i),
    .trig_o       (trig)
  );

  freq_window #(.CNT_W(CNT_W), .WIN_FALLS(WIN_FALLS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .rise_i    (rise_edge),
    .fall_i    (fall_edge),
    .count_o   (count_o),
    .ready_o   (ready_o),
    .counting_o(counting)
  );
endmodule

// File: rtl/clk_freq_meter_chk.sv
module clk_freq_meter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig,
  input logic             fall_edge,
  input logic             counting,
  input logic             meas_req_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ready_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_trig_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (count_o == '0 && !ready_o));

  p_req_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_i |=> (!ready_o && count_o == '0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !trig) |=> (ready_o && $stable(count_o)));

  p_ready_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(fall_edge));

  p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && !trig && count_o != CNT_MAX) |=> (count_o == $past(count_o) + CNT_W'(1)));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_MAX && !trig) |=> (count_o == CNT_MAX));

  p_ready_not_counting_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && counting));
endmodule

bind clk_freq_meter clk_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig      (trig),
  .fall_edge (fall_edge),
  .counting  (counting),
  .meas_req_i(meas_req_i),
  .count_o   (count_o),
  .ready_o   (ready_o)
);

// File: tb/tb_clk_freq_meter.sv
`timescale 1ns/1ps
module tb_clk_freq_meter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_clk_i = 1'b0;
  logic        src_sel_i = 1'b0;
  logic        rc_stable_i = 1'b0;
  logic        xtal_stable_i = 1'b0;
  logic        meas_req_i = 1'b0;
  logic [15:0] count_o;
  logic        ready_o;

  int tests = 0;
  int fails = 0;
  int hi_cyc = 10;
  int lo_cyc = 10;
  int unsigned cycles = 0;

  typedef struct {
    int    exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  clk_freq_meter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i),
    .src_sel_i(src_sel_i), .rc_stable_i(rc_stable_i),
    .xtal_stable_i(xtal_stable_i), .meas_req_i(meas_req_i),
    .count_o(count_o), .ready_o(ready_o)
  );

  always #2.5 clk_i = ~clk_i;

  // reference edges sit 1 ns off the fast grid
  initial begin
    #1;
    forever begin
      slow_clk_i = 1'b1; #(hi_cyc * 5);
      slow_clk_i = 1'b0; #(lo_cyc * 5);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      check(1'b0, "watchdog", int'(cycles), 190000);
      finish_run();
    end
  end

  // monitor: compare on every rising ready
  logic ready_q = 1'b0;
  always @(negedge clk_i) begin
    if (ready_o && !ready_q) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "unexpected result R8", int'(count_o), -1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(int'(count_o) == e.exp, e.tag, int'(count_o), e.exp);
      end
    end
    ready_q = ready_o;
  end

  task automatic set_ref(input int hi, input int lo);
    hi_cyc = hi;
    lo_cyc = lo;
    repeat (3) @(posedge slow_clk_i);
  endtask

  // kind: 0 request, 1 selection toggle, 2 rc rise, 3 xtal rise
  task automatic fire(input int kind);
    @(negedge clk_i);
    case (kind)
      0: meas_req_i = 1'b1;
      1: src_sel_i = ~src_sel_i;
      2: rc_stable_i = 1'b1;
      default: xtal_stable_i = 1'b1;
    endcase
    @(negedge clk_i);
    meas_req_i = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100000 && !ready_o; i++) @(negedge clk_i);
  endtask

  task automatic measure(input int kind, input int exp, input string tag);
    exp_t e;
    e.exp = exp;
    e.tag = tag;
    sb_q.push_back(e);
    fire(kind);
    wait_ready();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    check(count_o == 16'd0 && ready_o == 1'b0, "R11 reset state", int'(count_o), 0);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk_i);
    check(ready_o == 1'b0, "R11 idle without trigger", int'(ready_o), 0);

    set_ref(10, 10);
    measure(0, 10 + 15 * 20, "R1 R5 request, 50% duty");

    begin
      logic [15:0] held;
      held = count_o;
      repeat (80) @(negedge clk_i);
      check(ready_o && count_o == held, "R6 held after done", int'(count_o), int'(held));
    end

    set_ref(6, 14);
    measure(1, 6 + 15 * 20, "R1 R4 selection to crystal");

    set_ref(8, 8);
    begin
      exp_t e;
      e.exp = 8 + 15 * 16;
      e.tag = "R3 crystal stable rise";
      sb_q.push_back(e);
      fire(3);
      // fire() returns one edge after the trigger edge
      check(!ready_o && count_o == 16'd0, "R7 clear on trigger", int'(count_o), 0);
      wait_ready();
      @(negedge clk_i);
    end

    set_ref(5, 9);
    measure(1, 5 + 15 * 14, "R1 R4 selection back to rc");
    measure(2, 5 + 15 * 14, "R2 rc stable rise");

    begin
      logic [15:0] held;
      held = count_o;
      @(negedge clk_i); xtal_stable_i = 1'b0;
      repeat (3) @(negedge clk_i); rc_stable_i = 1'b0;
      repeat (3) @(negedge clk_i); xtal_stable_i = 1'b1;
      repeat (60) @(negedge clk_i);
      check(ready_o && count_o == held, "R9 non-triggers ignored", int'(count_o), int'(held));
      @(negedge clk_i); rc_stable_i = 1'b1;
      repeat (3) @(negedge clk_i);
      check(!ready_o && count_o < 16'd4, "R2 rc rise after fall retriggers", int'(count_o), 0);
      wait_ready();
      check(int'(count_o) == 5 + 15 * 14, "R2 retrigger result", int'(count_o), 5 + 15 * 14);
      ready_q = 1'b1;
      @(negedge clk_i);
    end

    set_ref(10, 10);
    begin
      exp_t e;
      e.exp = 10 + 15 * 20;
      e.tag = "R8 restart mid window";
      sb_q.push_back(e);
      fire(0);
      repeat (120) @(negedge clk_i);
      check(!ready_o && count_o != 16'd0, "R8 counting before restart", int'(count_o), 1);
      fire(0);
      check(count_o == 16'd0, "R8 restart clears", int'(count_o), 0);
      wait_ready();
      @(negedge clk_i);
    end

    set_ref(2200, 2200);
    measure(0, 65535, "R10 saturation");
    repeat (20) @(negedge clk_i);
    check(count_o == 16'hFFFF, "R10 saturated value held", int'(count_o), 65535);

    finish_run();
  end
endmodule